// File: doc/BRIEF.md
# CMI Line Encoder

This block turns a serial binary stream into Coded Mark Inversion line code. It runs on a fast clock at twice the bit rate and puts two code symbols on its serial output for every data bit. A zero always becomes a low symbol followed by a high symbol, so the line rises in the middle of the bit. A one becomes a pair of equal symbols. Successive ones take turns between a low pair and a high pair, and an internal polarity register remembers which pair comes next.

The block divides the fast clock by two and drives the result out as a bit-rate clock. A single phase toggle sets both this clock and the moment each data bit is sampled, so the upstream logic can launch its data from the divided clock. The alarm control replaces the sampled data with ones while it is held. The line then carries alternating low and high pairs, which a far-end decoder reads as a constant one.

The reset input is asynchronous and active low. Inside the block it is released in step with the fast clock. Data is sampled on the fast-clock edge where the divided clock is high. The first symbol of that bit leaves the output register three fast cycles later.

Top module: `cmi_line_encoder`

## Requirements
- R1: While reset is asserted, code_out is 0 and clk_half is 1.
- R2: Once running, clk_half changes value on every rising edge of clk_2x, so it has half the fast-clock frequency.
- R3: A sampled data bit of 0 is sent as symbol 0 followed by symbol 1.
- R4: A sampled data bit of 1 is sent as two equal symbols. Successive ones alternate between 00 and 11, and the first one after reset is sent as 00.
- R5: Zeros between ones leave the alternation of the ones unchanged.
- R6: The first symbol of a bit sampled at edge E appears on code_out after edge E+3 and the second after edge E+4. The first symbol is present while clk_half is 1, just after its rising edge.
- R7: din and ais_force are sampled only on a rising clk_2x edge where clk_half is 1. Their values at the other edges have no effect on code_out.
- R8: When ais_force is 1 at a sampling edge, the bit is coded as a 1 whatever din is, and it takes part in the same alternation as ordinary ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_2x | input | 1 | Symbol-rate clock, twice the data bit rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| din | input | 1 | Serial binary data bit |
| ais_force | input | 1 | Forces the sampled bit to 1, giving the all-ones alarm pattern |
| code_out | output | 1 | Coded line symbol |
| clk_half | output | 1 | Fast clock divided by two; rising edge marks the first symbol of a pair |

## Verification
The hardest case to reach is a change on din or ais_force at the edge between two sampling edges. It is invisible unless the stimulus is placed against the internal phase, which the ports reveal only through clk_half. The bench watches clk_half at each falling edge. It presents the real bit just before sampling edges and its inverse just before the other edges. The output pairs must then match the real bits alone. The alarm case mixes forced and ordinary bits in one run, so the polarity has to carry across the switch.

// File: rtl/cmi_pkg.sv
package cmi_pkg;
  // Symbol pair: bit 1 is sent first, bit 0 second.
  typedef logic [1:0] sym_pair_t;
  localparam sym_pair_t PAIR_ZERO = 2'b01;
  localparam sym_pair_t PAIR_LOW  = 2'b00;
  localparam sym_pair_t PAIR_HIGH = 2'b11;
  localparam int unsigned PIPE_CYCLES = 3;
endpackage

// File: rtl/cmi_rst_sync.sv
module cmi_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  generate
    if (STAGES < 2) begin : g_single
      logic stage_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= 1'b0;
        else        stage_q <= 1'b1;
      end
      assign rst_sync_n = stage_q;
    end else begin : g_chain
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
      end
      assign rst_sync_n = chain_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/cmi_phase_gen.sv
module cmi_phase_gen (
  input  logic clk,
  input  logic rst_n,
  output logic sample_en,
  output logic load_en,
  output logic clk_half
);
  logic phase_q, phase_d;
  logic half_q, half_d;

  always_comb begin
    phase_d = ~phase_q;
    half_d  = phase_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      half_q  <= 1'b1;
    end else begin
      phase_q <= phase_d;
      half_q  <= half_d;
    end
  end

  assign sample_en = ~phase_q;
  assign load_en   = phase_q;
  assign clk_half  = half_q;
endmodule

// File: rtl/cmi_pair_enc.sv
module cmi_pair_enc
  import cmi_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sample_en,
  input  logic      load_en,
  input  logic      din,
  input  logic      ais_force,
  output sym_pair_t pair
);
  logic      bit_q, bit_d;
  logic      pol_q, pol_d;
  sym_pair_t pair_q, pair_d;

  always_comb begin
    bit_d  = bit_q;
    pol_d  = pol_q;
    pair_d = pair_q;
    if (sample_en) begin
      bit_d = din | ais_force;
    end
    if (load_en) begin
      if (bit_q) begin
        pair_d = pol_q ? PAIR_HIGH : PAIR_LOW;
        pol_d  = ~pol_q;
      end else begin
        pair_d = PAIR_ZERO;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q  <= 1'b0;
      pol_q  <= 1'b0;
      pair_q <= PAIR_ZERO;
    end else begin
      bit_q  <= bit_d;
      pol_q  <= pol_d;
      pair_q <= pair_d;
    end
  end

  assign pair = pair_q;
endmodule

// File: rtl/cmi_serializer.sv
module cmi_serializer
  import cmi_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sample_en,
  input  logic      load_en,
  input  sym_pair_t pair,
  output logic      code_out
);
  logic second_q, second_d;
  logic code_q, code_d;

  always_comb begin
    second_d = second_q;
    code_d   = code_q;
    if (load_en) begin
      code_d   = pair[1];
      second_d = pair[0];
    end else if (sample_en) begin
      code_d = second_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      second_q <= 1'b0;
      code_q   <= 1'b0;
    end else begin
      second_q <= second_d;
      code_q   <= code_d;
    end
  end

  assign code_out = code_q;
endmodule

// File: rtl/cmi_line_encoder.sv
module cmi_line_encoder
  import cmi_pkg::*;
#(
  parameter int unsigned RST_STAGES = 2
) (
  input  logic clk_2x,
  input  logic rst_n,
  input  logic din,
  input  logic ais_force,
  output logic code_out,
  output logic clk_half
);
  logic      rst_core_n;
  logic      sample_en;
  logic      load_en;
  sym_pair_t pair;

  cmi_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk_2x),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  cmi_phase_gen u_phase (
    .clk       (clk_2x),
    .rst_n     (rst_core_n),
    .sample_en (sample_en),
    .load_en   (load_en),
    .clk_half  (clk_half)
  );

  cmi_pair_enc u_enc (
    .clk       (clk_2x),
    .rst_n     (rst_core_n),
    .sample_en (sample_en),
    .load_en   (load_en),
    .din       (din),
    .ais_force (ais_force),
    .pair      (pair)
  );

  cmi_serializer u_ser (
    .clk       (clk_2x),
    .rst_n     (rst_core_n),
    .sample_en (sample_en),
    .load_en   (load_en),
    .pair      (pair),
    .code_out  (code_out)
  );
endmodule

// File: rtl/cmi_line_encoder_chk.sv
module cmi_line_encoder_chk (
  input logic clk,
  input logic rst_core_n,
  input logic din,
  input logic ais_force,
  input logic code_out,
  input logic clk_half
);
  logic live_q;

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) live_q <= 1'b0;
    else             live_q <= 1'b1;
  end

  assert_reset_state_R1: assert property (@(posedge clk)
    !rst_core_n |=> (!code_out && clk_half));

  assert_half_toggle_R2: assert property (@(posedge clk) disable iff (!rst_core_n)
    live_q |-> (clk_half != $past(clk_half)));

  assert_zero_pair_R3: assert property (@(posedge clk) disable iff (!rst_core_n)
    (live_q && clk_half && !din && !ais_force) |-> ##4 !code_out ##1 code_out);

  assert_one_pair_R4: assert property (@(posedge clk) disable iff (!rst_core_n)
    (live_q && clk_half && din && !ais_force) |-> ##5 (code_out == $past(code_out)));

  assert_ais_pair_R8: assert property (@(posedge clk) disable iff (!rst_core_n)
    (live_q && clk_half && ais_force) |-> ##5 (code_out == $past(code_out)));
endmodule

bind cmi_line_encoder cmi_line_encoder_chk u_chk (
  .clk        (clk_2x),
  .rst_core_n (rst_core_n),
  .din        (din),
  .ais_force  (ais_force),
  .code_out   (code_out),
  .clk_half   (clk_half)
);

// File: tb/cmi_line_encoder_test.sv
`timescale 1ns/1ps
module cmi_line_encoder_test;
  logic clk_2x = 1'b0;
  logic rst_n;
  logic din;
  logic ais_force;
  logic code_out;
  logic clk_half;

  int checks = 0;
  int fails  = 0;
  logic model_pol;

  always #2 clk_2x = ~clk_2x;

  cmi_line_encoder uut (
    .clk_2x    (clk_2x),
    .rst_n     (rst_n),
    .din       (din),
    .ais_force (ais_force),
    .code_out  (code_out),
    .clk_half  (clk_half)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    din = 1'b0;
    ais_force = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk_2x);
    rst_n = 1'b1;
    model_pol = 1'b0;
    // wait until the divider has started
    for (int w = 0; w < 10; w++) begin
      @(negedge clk_2x);
      if (!clk_half) break;
    end
  endtask

  task automatic t_reset();
    din = 1'b1;
    ais_force = 1'b1;
    rst_n = 1'b0;
    repeat (4) @(negedge clk_2x);
    check(code_out == 1'b0, "R1 code_out in reset", code_out, 0);
    check(clk_half == 1'b1, "R1 clk_half in reset", clk_half, 1);
  endtask

  // Sends n bits; bit i uses dv[i] and av[i]. With noise, inverted values
  // are presented ahead of the edges that do not sample.
  task automatic run_seq(input logic [15:0] dv, input logic [15:0] av,
                         input int n, input bit noise, input string req);
    logic samp [64];
    logic hs   [64];
    int   cap  [16];
    int   idx = 0;
    int   len = 2 * n + 8;
    logic cur_d = 1'b0;
    logic cur_a = 1'b0;
    bit   tog_ok = 1'b1;
    do_reset();
    for (int k = 0; k < len; k++) begin
      @(negedge clk_2x);
      samp[k] = code_out;
      hs[k]   = clk_half;
      if (clk_half) begin
        if (idx < n) begin
          cur_d = dv[idx];
          cur_a = av[idx];
          cap[idx] = k;
          idx++;
        end else begin
          cur_d = 1'b0;
          cur_a = 1'b0;
        end
        din = cur_d;
        ais_force = cur_a;
      end else begin
        din = noise ? ~cur_d : cur_d;
        ais_force = noise ? ~cur_a : cur_a;
      end
    end
    for (int i = 0; i < n; i++) begin
      logic b;
      logic [1:0] exp_p;
      logic [1:0] act_p;
      b = dv[i] | av[i];
      if (b) begin
        exp_p = {model_pol, model_pol};
        model_pol = ~model_pol;
      end else begin
        exp_p = 2'b01;
      end
      act_p = {samp[cap[i] + 4], samp[cap[i] + 5]};
      check(act_p == exp_p, req, act_p, exp_p);
      check(hs[cap[i] + 4] == 1'b1, "R6 first symbol with clk_half high",
            hs[cap[i] + 4], 1);
    end
    for (int k = 1; k < len; k++)
      if (hs[k] == hs[k-1]) tog_ok = 1'b0;
    check(tog_ok, "R2 clk_half toggles each cycle", tog_ok, 1);
  endtask

  task automatic t_zeros();
    run_seq(16'h0000, 16'h0000, 8, 1'b0, "R3 R6 zero pair");
  endtask

  task automatic t_ones();
    run_seq(16'h00FF, 16'h0000, 8, 1'b0, "R4 alternating ones");
  endtask

  task automatic t_mixed();
    run_seq(16'b0110_1001_1101_0011, 16'h0000, 16, 1'b0, "R5 zeros between ones");
  endtask

  task automatic t_noise();
    run_seq(16'b1011_0010_0111_0101, 16'h0000, 16, 1'b1, "R7 off-edge input ignored");
  endtask

  task automatic t_ais();
    run_seq(16'b0000_0101_0000_1001, 16'b0000_1111_1100_0110, 16, 1'b0, "R8 forced ones");
  endtask

  initial begin
    repeat (100000) @(posedge clk_2x);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    din = 1'b0;
    ais_force = 1'b0;
    t_reset();
    t_zeros();
    t_ones();
    t_mixed();
    t_noise();
    t_ais();
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule